// File: doc/BRIEF.md
# Serial Ones-Count Controller

This block counts the bits set to 1 in a data word by shifting the word out one bit at a time. A pulse on the start input, given while the block is idle, captures the word into an internal shift register. A small four-state controller then alternates between shifting that register right and adding one to a result counter each time the bit shifted out is a 1. The run ends as soon as the shift register holds no more ones. The result then stays on the count output until the next accepted start.

The result counter is preset to all ones when a word is loaded. The controller always passes through its counting state once at the start of a run, so that first increment wraps the counter to zero. After that, every shift is followed by a test of the captured bit, and only a 1 leads back to the counting state. The number of busy cycles therefore depends on the data: one cycle for the first count, two cycles per shift, and one more cycle per set bit. A parameter selects how the next state is built: either as one multiplexer per state bit indexed by the present state, or as a plain case statement. Both variants give the same cycle behaviour.

Top module: `serial_ones_counter`

## Requirements
- R1: After reset, `done_o` is 1 and `count_o` is 0.
- R2: `done_o` is 1 exactly while the controller is idle. A `start_i` of 1 sampled while idle makes `done_o` 0 on the next cycle. While idle with `start_i` at 0, `done_o` stays 1.
- R3: When `done_o` returns to 1 after a run, `count_o` equals the number of 1 bits in the `data_i` value sampled with the accepted start.
- R4: For an all-zero word, `done_o` is 0 for exactly one cycle and `count_o` is 0 afterwards.
- R5: `start_i` and `data_i` have no effect while a run is in progress. The result and the run length depend only on the word captured at the accepted start.
- R6: While idle with `start_i` at 0, `count_o` holds the last result whatever `data_i` does.
- R7: The result never overflows. An all-ones word yields `count_o` = DATA_W, and an idle `count_o` never exceeds DATA_W.
- R8: A run keeps `done_o` at 0 for exactly 1 + 2·L + P cycles. P is the number of 1 bits in the word. L is the position of its highest set bit counted from 1 at bit 0, or 0 for a zero word.
- R9: Both next-state variants (NEXT_STATE_MUX = 1 and 0) meet R1 to R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when sampled high while idle |
| data_i | input | DATA_W | Word whose 1 bits are counted, captured at an accepted start |
| count_o | output | CNT_W | Result counter, holds the last result while idle |
| done_o | output | 1 | High while idle |

## Verification
The bench builds two instances side by side. One uses DATA_W = 8 with the multiplexer next-state variant. The other uses DATA_W = 5 with the case variant, which also has a 3-bit result counter that only just fits a count of five. Driving both with the same words, masked for the narrow one, exercises both next-state variants and their run lengths, which depend on the data. The all-ones words reach the widest counts each counter can hold. A single high bit at the top of the word gives the longest run of zero shifts. Random start and data activity during each run, and while idle, shows that both inputs are ignored outside an accepted start.

// File: rtl/serial_ones_counter_pkg.sv
package serial_ones_counter_pkg;

   // Present-state codes; the multiplexer next-state variant indexes by them.
   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_COUNT = 2'b01,
      ST_SHIFT = 2'b10,
      ST_TEST  = 2'b11
   } ocnt_state_e;

   typedef struct packed {
      logic load;    // capture word, preset result counter
      logic incr;    // add one to result counter
      logic shift;   // shift word right, capture dropped bit
      logic idle;    // controller waiting for start
   } ocnt_ctrl_t;

   function automatic int min_cnt_width(input int data_w);
      return $clog2(data_w + 1);
   endfunction

endpackage

// File: rtl/ocnt_shifter.sv
module ocnt_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              shift_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              empty_o,
   output logic              dropped_o
);

   logic [DATA_W-1:0] word_q;
   logic [DATA_W-1:0] shifted;
   logic              drop_q;

   generate
      if (DATA_W == 1) begin : g_single
         assign shifted = '0;
      end else begin : g_multi
         assign shifted = {1'b0, word_q[DATA_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         word_q <= '0;
         drop_q <= 1'b0;
      end else if (load_i) begin
         word_q <= data_i;
      end else if (shift_i) begin
         word_q <= shifted;
         drop_q <= word_q[0];
      end
   end

   assign empty_o   = (word_q == '0);
   assign dropped_o = drop_q;

   // A shift of a nonzero word always makes it strictly smaller.
   AST_SHIFT_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shift_i && !load_i && word_q != '0) |=> (word_q < $past(word_q)));  // R3

   // The top bit is always zero after a shift.
   AST_ZERO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shift_i && !load_i) |=> !word_q[DATA_W-1]);  // R3

endmodule

// File: rtl/ocnt_result.sv
module ocnt_result #(
   parameter int CNT_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             preset_i,
   input  logic             incr_i,
   output logic [CNT_W-1:0] count_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (preset_i) begin
         cnt_q <= '1;
      end else if (incr_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count_o = cnt_q;

   // Preset value is all ones, so the first increment lands on zero.
   AST_PRESET_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      preset_i |=> ##1 (count_o == '0));  // R4

endmodule

// File: rtl/ocnt_ctrl.sv
module ocnt_ctrl
   import serial_ones_counter_pkg::*;
#(
   parameter bit NEXT_STATE_MUX = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       start_i,
   input  logic       empty_i,
   input  logic       dropped_i,
   output ocnt_ctrl_t ctrl_o
);

   ocnt_state_e state_q;
   ocnt_state_e state_d;
   logic [3:0]  state_dec;

   generate
      if (NEXT_STATE_MUX) begin : g_mux_next
         // One 4-input multiplexer per state bit, indexed by the present state.
         logic [3:0] hi_in;
         logic [3:0] lo_in;
         always_comb begin
            hi_in[ST_IDLE]  = 1'b0;
            lo_in[ST_IDLE]  = start_i;
            hi_in[ST_COUNT] = !empty_i;
            lo_in[ST_COUNT] = 1'b0;
            hi_in[ST_SHIFT] = 1'b1;
            lo_in[ST_SHIFT] = 1'b1;
            hi_in[ST_TEST]  = !dropped_i;
            lo_in[ST_TEST]  = dropped_i;
         end
         assign state_d = ocnt_state_e'({hi_in[state_q], lo_in[state_q]});
      end else begin : g_case_next
         always_comb begin
            state_d = state_q;
            unique case (state_q)
               ST_IDLE:  if (start_i) state_d = ST_COUNT;
               ST_COUNT: state_d = empty_i ? ST_IDLE : ST_SHIFT;
               ST_SHIFT: state_d = ST_TEST;
               ST_TEST:  state_d = dropped_i ? ST_COUNT : ST_SHIFT;
               default:  state_d = ST_IDLE;
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   // Decoder level: one line per state.
   always_comb begin
      state_dec = '0;
      state_dec[state_q] = 1'b1;
   end

   assign ctrl_o.idle  = state_dec[ST_IDLE];
   assign ctrl_o.load  = state_dec[ST_IDLE] & start_i;
   assign ctrl_o.incr  = state_dec[ST_COUNT];
   assign ctrl_o.shift = state_dec[ST_SHIFT];

   AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({ctrl_o.load, ctrl_o.incr, ctrl_o.shift}));  // R9

   // A shift is always followed by a test of the dropped bit.
   AST_SHIFT_THEN_TEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_o.shift |=> (state_q == ST_TEST));  // R8

   // An empty word seen while counting ends the run.
   AST_EMPTY_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_o.incr && empty_i) |=> ctrl_o.idle);  // R4

endmodule

// File: rtl/serial_ones_counter.sv
module serial_ones_counter
   import serial_ones_counter_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int CNT_W          = $clog2(DATA_W + 1),
   parameter bit NEXT_STATE_MUX = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CNT_W-1:0]  count_o,
   output logic              done_o
);

   localparam int NEED_W = min_cnt_width(DATA_W);

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("DATA_W must be at least 1");
      end
      if (CNT_W < NEED_W) begin : g_bad_cnt_w
         $error("CNT_W too narrow to hold a full count of DATA_W");
      end
   endgenerate

   ocnt_ctrl_t ctrl;
   logic       empty;
   logic       dropped;

   ocnt_ctrl #(
      .NEXT_STATE_MUX(NEXT_STATE_MUX)
   ) u_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start_i),
      .empty_i  (empty),
      .dropped_i(dropped),
      .ctrl_o   (ctrl)
   );

   ocnt_shifter #(
      .DATA_W(DATA_W)
   ) u_shifter (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (ctrl.load),
      .shift_i  (ctrl.shift),
      .data_i   (data_i),
      .empty_o  (empty),
      .dropped_o(dropped)
   );

   ocnt_result #(
      .CNT_W(CNT_W)
   ) u_result (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .preset_i(ctrl.load),
      .incr_i  (ctrl.incr),
      .count_o (count_o)
   );

   assign done_o = ctrl.idle;

   AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !start_i) |=> done_o);  // R2

   AST_START_LEAVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && start_i) |=> !done_o);  // R2

   AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !start_i) |=> $stable(count_o));  // R6

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (count_o <= CNT_W'(DATA_W)));  // R7

endmodule

// File: tb/serial_ones_counter_tb_top.sv
module serial_ones_counter_tb_top;

   localparam int CLK_P   = 10;
   localparam int WA      = 8;
   localparam int WB      = 5;
   localparam int CA      = $clog2(WA + 1);
   localparam int CB      = $clog2(WB + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_a = 1'b0, start_b = 1'b0;
   logic [WA-1:0] data_a = '0;
   logic [WB-1:0] data_b = '0;
   logic [CA-1:0] count_a;
   logic [CB-1:0] count_b;
   logic          done_a, done_b;

   int checks = 0;
   int bad    = 0;
   bit ended  = 0;

   always #(CLK_P/2) clk = ~clk;

   serial_ones_counter #(.DATA_W(WA), .NEXT_STATE_MUX(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start_a), .data_i(data_a),
      .count_o(count_a), .done_o(done_a));

   serial_ones_counter #(.DATA_W(WB), .NEXT_STATE_MUX(1'b0)) dut_nar_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start_b), .data_i(data_b),
      .count_o(count_b), .done_o(done_b));

   function automatic int pop_w(input logic [7:0] w, input int width);
      int n = 0;
      for (int i = 0; i < width; i++) if (w[i]) n++;
      return n;
   endfunction

   function automatic int len_w(input logic [7:0] w, input int width);
      int n = 0;
      for (int i = 0; i < width; i++) if (w[i]) n = i + 1;
      return n;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One run on both instances; noisy drives start/data randomly while busy.
   task automatic run_word(input logic [7:0] w, input bit noisy);
      int  busy_a = 0, busy_b = 0;
      bit  fin_a = 0, fin_b = 0;
      int  exp_a, exp_b;
      @(negedge clk);
      data_a = w; data_b = w[WB-1:0];
      start_a = 1'b1; start_b = 1'b1;
      @(negedge clk);
      start_a = 1'b0; start_b = 1'b0;
      for (int g = 0; g < 200; g++) begin
         if (!fin_a) begin if (done_a) fin_a = 1; else busy_a++; end
         if (!fin_b) begin if (done_b) fin_b = 1; else busy_b++; end
         if (fin_a && fin_b) break;
         if (noisy) begin
            if (!fin_a) begin start_a = 1'($urandom); data_a = WA'($urandom); end
            if (!fin_b) begin start_b = 1'($urandom); data_b = WB'($urandom); end
         end
         if (fin_a) start_a = 1'b0;
         if (fin_b) start_b = 1'b0;
         @(negedge clk);
      end
      start_a = 1'b0; start_b = 1'b0;
      exp_a = 1 + 2 * len_w(w, WA) + pop_w(w, WA);
      exp_b = 1 + 2 * len_w(w, WB) + pop_w(w, WB);
      check(busy_a == exp_a, "R8 wide run length (R5 when noisy)", busy_a, exp_a);
      check(busy_b == exp_b, "R8 narrow run length (R9 case variant)", busy_b, exp_b);
      check(int'(count_a) == pop_w(w, WA), "R3 wide result (R5 when noisy)", count_a, pop_w(w, WA));
      check(int'(count_b) == pop_w(w, WB), "R3 narrow result (R9 case variant)", count_b, pop_w(w, WB));
   endtask

   // Idle with random data and no start: result and done must hold.
   task automatic idle_hold(input int cycles);
      logic [CA-1:0] ka = count_a;
      logic [CB-1:0] kb = count_b;
      bit ok = 1;
      for (int i = 0; i < cycles; i++) begin
         data_a = WA'($urandom); data_b = WB'($urandom);
         @(negedge clk);
         if (count_a != ka || count_b != kb || !done_a || !done_b) ok = 0;
      end
      check(ok, "R6 result held while idle (R2 done stays high)", count_a, ka);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      #(CLK_P * 3);
      check(done_a && done_b, "R1 done after reset", done_a, 1);
      check(count_a == 0 && count_b == 0, "R1 count after reset", count_a, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(done_a && count_a == 0, "R1 state held after reset release", count_a, 0);

      // R2: start drops done on the next cycle
      data_a = 8'h03; data_b = 5'h03; start_a = 1'b1; start_b = 1'b1;
      @(negedge clk);
      start_a = 1'b0; start_b = 1'b0;
      check(!done_a && !done_b, "R2 done low after start", done_a, 0);
      repeat (20) @(negedge clk);
      check(count_a == 2 && count_b == 2, "R3 small word result", count_a, 2);

      run_word(8'h00, 0);                // R4 zero word, one busy cycle
      check(count_a == 0, "R4 zero word result", count_a, 0);
      run_word(8'hFF, 0);                // R7 all ones: 8 and 5
      check(count_a == CA'(WA) && count_b == CB'(WB), "R7 full count no overflow", count_a, WA);
      run_word(8'h1F, 0);                // narrow full, wide five
      run_word(8'h80, 0);                // long zero shifts, narrow sees zero (R4)
      run_word(8'h01, 0);
      run_word(8'hAA, 1);                // R5 noise during run
      idle_hold(6);
      run_word(8'h55, 1);
      idle_hold(4);

      for (int k = 0; k < 30; k++) begin
         run_word(8'($urandom), k[0]);
         if (k % 5 == 0) idle_hold(3);
      end

      ended = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      if (!ended) begin
         checks++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

endmodule